// File: doc/BRIEF.md
# Access-Kind Split Translation Cache

This block is a direct-mapped address translation cache placed between a core's memory pipeline and an external page table walker. Every set holds one physical page number that all access kinds share, and three separate virtual page tags: one for loads, one for stores and one for instruction fetches. A lookup hits only when the tag for its own access kind matches. A page is therefore cached only for the kinds of access that have already been granted by a walk. A store to a page that has only been read before still goes to the walker, which checks write permission and marks the page dirty.

A request carries a virtual address, an access kind and the current privilege controls. When translation is off, the physical address is the virtual address, and it is checked only against a memory size limit. Otherwise a hit answers on the next cycle. A miss raises a walk request and holds it until the walker answers. Exactly one miss is in flight at a time, and new requests stall until the walker answers. A walk that succeeds refills the set. A failed walk or an out-of-range bypass access produces a fault whose code depends on the access kind. A flush input drops every cached tag in one cycle.

Top module: `kind_tlb`

## Requirements
- R1: After reset every tag is invalid, so the first translated lookup of any page misses. Also after reset `rsp_valid_o` and `walk_req_o` are low and `req_ready_o` is high.
- R2: A translated request accepted in cycle N that hits gives `rsp_valid_o` in cycle N+1. Its `rsp_paddr_o` is the set's stored page number joined with the low 12 address bits. No walk is requested.
- R3: The set index is the virtual page number (address bits above bit 11) modulo ENTRIES. The tag is the whole virtual page number. A lookup hits only if the tag for its own kind matches; the kind codes are 0 load, 1 store, 2 fetch.
- R4: On a refill, every one of the set's three tags that differs from the new page number is invalidated. After that, only the tag of the requesting kind is written with the new page number.
- R5: Every refill overwrites the set's shared page number with the one the walker returned. A later hit of another kind in that set therefore uses the new page number.
- R6: Translation is bypassed when `vm_bare_i` is 1. It is also bypassed when `priv_i` is machine (3) and either the access is a fetch or `mprv_i` is machine (3); the other privilege codes are 0 user and 1 supervisor. A bypassed access answers in the next cycle with the address itself as physical address, and it does not request a walk.
- R7: A bypassed access whose address is greater than or equal to `mem_limit_i` faults.
- R8: `walk_sup_o` is 1 when `priv_i` is supervisor (1), or when `priv_i` is machine (3) and `mprv_i` is supervisor (1).
- R9: A faulting response sets `rsp_fault_o` and carries `rsp_cause_o` = 1 for a fetch, 3 for a store and 2 for any other kind. A response without a fault carries cause 0.
- R10: When the walker reports a fault, the request gets a fault response and nothing is refilled, so the same access misses again.
- R11: A cycle with `flush_i` high invalidates every tag of every set, and no request is accepted in that cycle. If a refill falls in the same cycle, the flush wins.
- R12: From the cycle after a miss is accepted until the walker answers, `walk_req_o` stays high with a stable `walk_vpn_o` and `req_ready_o` stays low. The response comes in the cycle after `walk_rsp_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Lookup request |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_vaddr_i | input | VA_W | Virtual address |
| req_kind_i | input | 2 | 0 load, 1 store, 2 fetch |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mprv_i | input | 2 | Privilege used for machine-mode data accesses |
| vm_bare_i | input | 1 | Translation switched off |
| mem_limit_i | input | PA_W | Memory size limit for bypassed accesses |
| flush_i | input | 1 | Invalidate all tags |
| rsp_valid_o | output | 1 | Response valid |
| rsp_paddr_o | output | PA_W | Physical address |
| rsp_fault_o | output | 1 | Access fault |
| rsp_cause_o | output | 2 | Fault kind: 0 none, 1 fetch, 2 load, 3 store |
| walk_req_o | output | 1 | Walk requested |
| walk_vpn_o | output | VA_W-12 | Virtual page number to walk |
| walk_sup_o | output | 1 | Walk with supervisor permissions |
| walk_store_o | output | 1 | Walk is for a store |
| walk_fetch_o | output | 1 | Walk is for a fetch |
| walk_rsp_i | input | 1 | Walker answer valid |
| walk_fault_i | input | 1 | Walker found no legal mapping |
| walk_ppn_i | input | PA_W-12 | Physical page number from walker |

## Verification
The assertions assume that the walker raises `walk_rsp_i` only while `walk_req_o` is high, as a single-cycle pulse, and that `req_kind_i` never takes the reserved code 3. The bench's walker model answers only a request it has seen, always after one idle cycle, and drops its pulse after one cycle. The stimulus draws kinds only from load, store and fetch. Requests are issued one at a time, and each one starts only after the previous response, so the stall condition is never contested.

// File: rtl/kt_pkg.sv
package kt_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PRV_U = 2'd0,
        PRV_S = 2'd1,
        PRV_H = 2'd2,
        PRV_M = 2'd3
    } prv_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_IFETCH = 2'd1,
        CAUSE_LOAD   = 2'd2,
        CAUSE_STORE  = 2'd3
    } cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } state_e;

    typedef struct packed {
        logic bare;
        prv_e priv;
        prv_e mprv;
    } mode_t;

    localparam int unsigned NUM_KINDS = 3;

    function automatic cause_e fault_cause(input acc_e kind);
        case (kind)
            ACC_FETCH: return CAUSE_IFETCH;
            ACC_STORE: return CAUSE_STORE;
            default:   return CAUSE_LOAD;
        endcase
    endfunction

    function automatic logic [1:0] bank_of(input acc_e kind);
        case (kind)
            ACC_FETCH: return 2'd2;
            ACC_STORE: return 2'd1;
            default:   return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/kt_mode_decode.sv
module kt_mode_decode
    import kt_pkg::*;
#(
    parameter int unsigned VA_W = 39,
    parameter int unsigned PA_W = 44
) (
    input  mode_t             mode_i,
    input  acc_e              kind_i,
    input  logic [VA_W-1:0]   vaddr_i,
    input  logic [PA_W-1:0]   limit_i,
    output logic              bypass_o,
    output logic              sup_o,
    output logic              over_limit_o,
    output logic [PA_W-1:0]   bypass_pa_o
);
    localparam int unsigned CMP_W = (VA_W > PA_W) ? VA_W : PA_W;

    logic             in_machine;
    logic [CMP_W-1:0] va_ext;
    logic [CMP_W-1:0] lim_ext;

    assign in_machine = (mode_i.priv == PRV_M);

    // translation off: bare mode, or machine mode fetching / using own privilege
    assign bypass_o = mode_i.bare
                    | (in_machine & ((kind_i == ACC_FETCH) | (mode_i.mprv == PRV_M)));

    // walker permission set
    assign sup_o = (mode_i.priv == PRV_S)
                 | (in_machine & (mode_i.mprv == PRV_S));

    assign va_ext       = CMP_W'(vaddr_i);
    assign lim_ext      = CMP_W'(limit_i);
    assign over_limit_o = (va_ext >= lim_ext);
    assign bypass_pa_o  = PA_W'(vaddr_i);

endmodule

// File: rtl/kt_tag_bank.sv
module kt_tag_bank #(
    parameter int unsigned SETS  = 16,
    parameter int unsigned TAG_W = 28
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush_i,
    input  logic [$clog2(SETS)-1:0] rd_idx_i,
    input  logic [TAG_W-1:0]        rd_tag_i,
    output logic                    hit_o,
    input  logic                    refill_i,
    input  logic                    owner_i,
    input  logic [$clog2(SETS)-1:0] wr_idx_i,
    input  logic [TAG_W-1:0]        wr_tag_i
);
    localparam logic [TAG_W-1:0] TAG_NONE = '1;

    logic [TAG_W-1:0] tags [SETS];

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            for (int s = 0; s < SETS; s++) begin
                tags[s] <= TAG_NONE;
            end
        end else if (refill_i) begin
            if (owner_i) begin
                tags[wr_idx_i] <= wr_tag_i;
            end else if (tags[wr_idx_i] != wr_tag_i) begin
                tags[wr_idx_i] <= TAG_NONE;
            end
        end
    end

    assign hit_o = (tags[rd_idx_i] == rd_tag_i);

    // R11: after a flush nothing in this bank can match a real tag
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !hit_o);

endmodule

// File: rtl/kt_page_store.sv
module kt_page_store #(
    parameter int unsigned SETS  = 16,
    parameter int unsigned PPN_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en_i,
    input  logic [$clog2(SETS)-1:0] wr_idx_i,
    input  logic [PPN_W-1:0]        wr_ppn_i,
    input  logic [$clog2(SETS)-1:0] rd_idx_i,
    output logic [PPN_W-1:0]        rd_ppn_o
);
    logic [PPN_W-1:0] ppns [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                ppns[s] <= '0;
            end
        end else if (wr_en_i) begin
            ppns[wr_idx_i] <= wr_ppn_i;
        end
    end

    assign rd_ppn_o = ppns[rd_idx_i];

endmodule

// File: rtl/kind_tlb.sv
module kind_tlb
    import kt_pkg::*;
#(
    parameter int unsigned VA_W     = 39,
    parameter int unsigned PA_W     = 44,
    parameter int unsigned ENTRIES  = 16,
    parameter int unsigned PG_SHIFT = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic [VA_W-1:0]        req_vaddr_i,
    input  logic [1:0]             req_kind_i,
    input  logic [1:0]             priv_i,
    input  logic [1:0]             mprv_i,
    input  logic                   vm_bare_i,
    input  logic [PA_W-1:0]        mem_limit_i,
    input  logic                   flush_i,
    output logic                   rsp_valid_o,
    output logic [PA_W-1:0]        rsp_paddr_o,
    output logic                   rsp_fault_o,
    output logic [1:0]             rsp_cause_o,
    output logic                   walk_req_o,
    output logic [VA_W-PG_SHIFT-1:0] walk_vpn_o,
    output logic                   walk_sup_o,
    output logic                   walk_store_o,
    output logic                   walk_fetch_o,
    input  logic                   walk_rsp_i,
    input  logic                   walk_fault_i,
    input  logic [PA_W-PG_SHIFT-1:0] walk_ppn_i
);
    localparam int unsigned VPN_W = VA_W - PG_SHIFT;
    localparam int unsigned PPN_W = PA_W - PG_SHIFT;
    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned TAG_W = VPN_W + 1;

    // ---------------- request decode ----------------
    mode_t               mode;
    acc_e                kind;
    logic                accept;
    logic                bypass;
    logic                sup;
    logic                over_limit;
    logic [PA_W-1:0]     bypass_pa;
    logic [VPN_W-1:0]    req_vpn;
    logic [IDX_W-1:0]    req_idx;
    logic [TAG_W-1:0]    req_tag;
    logic [PG_SHIFT-1:0] req_off;

    assign mode.bare = vm_bare_i;
    assign mode.priv = prv_e'(priv_i);
    assign mode.mprv = prv_e'(mprv_i);
    assign kind      = acc_e'(req_kind_i);

    assign req_vpn = req_vaddr_i[VA_W-1:PG_SHIFT];
    assign req_off = req_vaddr_i[PG_SHIFT-1:0];
    assign req_idx = req_vpn[IDX_W-1:0];
    assign req_tag = {1'b0, req_vpn};

    kt_mode_decode #(
        .VA_W (VA_W),
        .PA_W (PA_W)
    ) u_decode (
        .mode_i       (mode),
        .kind_i       (kind),
        .vaddr_i      (req_vaddr_i),
        .limit_i      (mem_limit_i),
        .bypass_o     (bypass),
        .sup_o        (sup),
        .over_limit_o (over_limit),
        .bypass_pa_o  (bypass_pa)
    );

    // ---------------- miss state ----------------
    state_e              st_q;
    logic [VPN_W-1:0]    pend_vpn_q;
    logic [PG_SHIFT-1:0] pend_off_q;
    acc_e                pend_kind_q;
    logic                pend_sup_q;

    assign req_ready_o = (st_q == ST_IDLE) && !flush_i;
    assign accept      = req_valid_i && req_ready_o;

    // ---------------- tag banks and page store ----------------
    logic                refill;
    logic [IDX_W-1:0]    fill_idx;
    logic [TAG_W-1:0]    fill_tag;
    logic [1:0]          fill_bank;
    logic [NUM_KINDS-1:0] bank_hit;
    logic                hit;
    logic [PPN_W-1:0]    set_ppn;

    assign refill    = (st_q == ST_WALK) && walk_rsp_i && !walk_fault_i && !flush_i;
    assign fill_idx  = pend_vpn_q[IDX_W-1:0];
    assign fill_tag  = {1'b0, pend_vpn_q};
    assign fill_bank = bank_of(pend_kind_q);

    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_bank
        kt_tag_bank #(
            .SETS  (ENTRIES),
            .TAG_W (TAG_W)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .flush_i  (flush_i),
            .rd_idx_i (req_idx),
            .rd_tag_i (req_tag),
            .hit_o    (bank_hit[g]),
            .refill_i (refill),
            .owner_i  (fill_bank == 2'(g)),
            .wr_idx_i (fill_idx),
            .wr_tag_i (fill_tag)
        );
    end

    assign hit = bank_hit[bank_of(kind)];

    kt_page_store #(
        .SETS  (ENTRIES),
        .PPN_W (PPN_W)
    ) u_pages (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (refill),
        .wr_idx_i (fill_idx),
        .wr_ppn_i (walk_ppn_i),
        .rd_idx_i (req_idx),
        .rd_ppn_o (set_ppn)
    );

    // ---------------- sequencing and response ----------------
    logic            rsp_valid_q;
    logic [PA_W-1:0] rsp_paddr_q;
    logic            rsp_fault_q;
    cause_e          rsp_cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            pend_vpn_q  <= '0;
            pend_off_q  <= '0;
            pend_kind_q <= ACC_LOAD;
            pend_sup_q  <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_paddr_q <= '0;
            rsp_fault_q <= 1'b0;
            rsp_cause_q <= CAUSE_NONE;
        end else begin
            rsp_valid_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (bypass) begin
                            rsp_valid_q <= 1'b1;
                            rsp_fault_q <= over_limit;
                            rsp_cause_q <= over_limit ? fault_cause(kind) : CAUSE_NONE;
                            rsp_paddr_q <= over_limit ? '0 : bypass_pa;
                        end else if (hit) begin
                            rsp_valid_q <= 1'b1;
                            rsp_fault_q <= 1'b0;
                            rsp_cause_q <= CAUSE_NONE;
                            rsp_paddr_q <= {set_ppn, req_off};
                        end else begin
                            st_q        <= ST_WALK;
                            pend_vpn_q  <= req_vpn;
                            pend_off_q  <= req_off;
                            pend_kind_q <= kind;
                            pend_sup_q  <= sup;
                        end
                    end
                end
                ST_WALK: begin
                    if (walk_rsp_i) begin
                        st_q        <= ST_IDLE;
                        rsp_valid_q <= 1'b1;
                        rsp_fault_q <= walk_fault_i;
                        rsp_cause_q <= walk_fault_i ? fault_cause(pend_kind_q) : CAUSE_NONE;
                        rsp_paddr_q <= walk_fault_i ? '0 : {walk_ppn_i, pend_off_q};
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid_o  = rsp_valid_q;
    assign rsp_paddr_o  = rsp_paddr_q;
    assign rsp_fault_o  = rsp_fault_q;
    assign rsp_cause_o  = rsp_cause_q;

    assign walk_req_o   = (st_q == ST_WALK);
    assign walk_vpn_o   = pend_vpn_q;
    assign walk_sup_o   = pend_sup_q;
    assign walk_store_o = (pend_kind_q == ACC_STORE);
    assign walk_fetch_o = (pend_kind_q == ACC_FETCH);

    // ---------------- assertions ----------------
    // R12: no new request is taken while a walk is outstanding
    a_r12_stall_in_walk: assert property (@(posedge clk) disable iff (rst)
        walk_req_o |-> !req_ready_o);

    // R12: an unanswered walk request stays up with the same page number
    a_r12_walk_held: assert property (@(posedge clk) disable iff (rst)
        (walk_req_o && !walk_rsp_i) |=> (walk_req_o && $stable(walk_vpn_o)));

    // R2: a translated hit answers in the next cycle without the walker
    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (accept && !bypass && hit) |=> (rsp_valid_o && !walk_req_o));

    // R6: a bypassed access never reaches the walker
    a_r6_bypass_no_walk: assert property (@(posedge clk) disable iff (rst)
        (accept && bypass) |=> (rsp_valid_o && !walk_req_o));

    // R9: a cause code is present exactly when the response faults
    a_r9_cause_matches_fault: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |-> (rsp_fault_o == (rsp_cause_o != 2'd0)));

endmodule

// File: tb/kind_tlb_test.sv
`timescale 1ns/1ps
module kind_tlb_test;
    localparam int VA_W = 20;
    localparam int PA_W = 20;
    localparam int ENT  = 4;
    localparam int INV  = -1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid_i = 1'b0;
    logic req_ready_o;
    logic [VA_W-1:0] req_vaddr_i = '0;
    logic [1:0] req_kind_i = '0, priv_i = '0, mprv_i = '0;
    logic vm_bare_i = 1'b0;
    logic [PA_W-1:0] mem_limit_i = 20'h80000;
    logic flush_i = 1'b0;
    logic rsp_valid_o, rsp_fault_o;
    logic [PA_W-1:0] rsp_paddr_o;
    logic [1:0] rsp_cause_o;
    logic walk_req_o, walk_sup_o, walk_store_o, walk_fetch_o;
    logic [VA_W-13:0] walk_vpn_o;
    logic walk_rsp_i = 1'b0, walk_fault_i = 1'b0;
    logic [PA_W-13:0] walk_ppn_i = '0;

    int total = 0, bad = 0, salt = 3;
    int mtag [3][ENT];
    int mppn [ENT];

    always #2.5 clk = ~clk;

    kind_tlb #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(ENT), .PG_SHIFT(12)) uut (.*);

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 3; k++) for (int s = 0; s < ENT; s++) mtag[k][s] = INV;
    endtask

    task automatic access(input logic [19:0] va, input int kind, input int pv, input int mp,
                          input bit bare, input bit wf, input string rq);
        int vpn = int'(va[19:12]);
        int s = vpn % ENT;
        bit byp = bare || (pv == 3 && (kind == 2 || mp == 3));
        bit esup = (pv == 1) || (pv == 3 && mp == 1);
        bit ehit = !byp && (mtag[kind][s] == vpn);
        int give = (vpn * 7 + salt) & 8'hFF;
        bit walked = 1'b0;
        bit efault;
        int ecause, epa;
        @(negedge clk);
        req_valid_i = 1'b1; req_vaddr_i = va; req_kind_i = 2'(kind);
        priv_i = 2'(pv); mprv_i = 2'(mp); vm_bare_i = bare;
        @(negedge clk);
        req_valid_i = 1'b0;
        if (walk_req_o) begin
            walked = 1'b1;
            chk(walk_sup_o == esup, "R8", "walk_sup", walk_sup_o, esup);
            chk(!req_ready_o, "R12", "ready during walk", req_ready_o, 0);
            chk(int'(walk_vpn_o) == vpn, "R12", "walk_vpn", walk_vpn_o, vpn);
            @(negedge clk);
            chk(walk_req_o && int'(walk_vpn_o) == vpn, "R12", "walk held", walk_req_o, 1);
            walk_rsp_i = 1'b1; walk_fault_i = wf; walk_ppn_i = 8'(give);
            @(negedge clk);
            walk_rsp_i = 1'b0; walk_fault_i = 1'b0;
        end
        chk(walked == (!byp && !ehit), rq, "walk requested", walked, !byp && !ehit);
        chk(rsp_valid_o, "R2", "response timing", rsp_valid_o, 1);
        efault = byp ? (int'(va) >= int'(mem_limit_i)) : (walked && wf);
        ecause = !efault ? 0 : (kind == 2) ? 1 : (kind == 1) ? 3 : 2;
        chk(rsp_fault_o == efault, byp ? "R7" : "R10", "fault", rsp_fault_o, efault);
        chk(int'(rsp_cause_o) == ecause, "R9", "cause", rsp_cause_o, ecause);
        if (!efault) begin
            epa = byp ? int'(va) : (((walked ? give : mppn[s]) << 12) | int'(va[11:0]));
            chk(int'(rsp_paddr_o) == epa, byp ? "R6" : rq, "paddr", rsp_paddr_o, epa);
        end
        if (walked && !wf) begin
            for (int k = 0; k < 3; k++) if (mtag[k][s] != vpn) mtag[k][s] = INV;
            mtag[kind][s] = vpn;
            mppn[s] = give;
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_i = 1'b1;
        #0.1;
        chk(!req_ready_o, "R11", "ready during flush", req_ready_o, 0);
        @(negedge clk);
        flush_i = 1'b0;
        model_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_clear();
        for (int s = 0; s < ENT; s++) mppn[s] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rsp_valid_o && !walk_req_o && req_ready_o, "R1", "idle after reset",
            {rsp_valid_o, walk_req_o, req_ready_o}, 3'b001);
        access(20'h12345, 0, 1, 0, 0, 0, "R1");          // cold miss
        access(20'h12abc, 0, 1, 0, 0, 0, "R2");          // hit
        access(20'h12004, 1, 1, 0, 0, 0, "R3");          // store tag separate: miss
        access(20'h12008, 0, 0, 0, 0, 0, "R4");          // load tag kept
        access(20'h1200c, 2, 0, 0, 0, 0, "R3");          // fetch miss
        access(20'h12010, 1, 0, 0, 0, 0, "R4");          // store still present
        access(20'h16020, 1, 0, 0, 0, 0, "R4");          // same set, new page
        access(20'h12030, 0, 0, 0, 0, 0, "R4");          // load of old page dropped
        access(20'h12034, 2, 0, 0, 0, 0, "R4");          // fetch of old page dropped
        salt = 40;
        access(20'h33100, 0, 1, 0, 0, 0, "R5");
        salt = 91;
        access(20'h33200, 2, 1, 0, 0, 0, "R5");          // refill replaces page number
        access(20'h33300, 0, 1, 0, 0, 0, "R5");          // load hit sees new number
        access(20'h45000, 1, 1, 0, 0, 1, "R10");         // walker fault
        access(20'h45004, 1, 1, 0, 0, 0, "R10");         // misses again
        do_flush();
        access(20'h45008, 1, 1, 0, 0, 0, "R11");
        access(20'h3330c, 0, 1, 0, 0, 0, "R11");
        // mode sweep
        for (int b = 0; b < 2; b++)
            for (int pi = 0; pi < 3; pi++)
                for (int mi = 0; mi < 3; mi++)
                    for (int k = 0; k < 3; k++)
                        for (int a = 0; a < 2; a++)
                            access(a ? 20'h98765 : 20'h34567, k, (pi == 2) ? 3 : pi,
                                   (mi == 2) ? 3 : mi, b[0], 1'b0, "R6");
        // page sweep with colliding sets and occasional walker faults
        for (int i = 0; i < 240; i++) begin
            salt = i % 9;
            if (i == 120) do_flush();
            access(20'(((i * 37) % 24) << 12 | ((i * 13) & 12'hFFF)), i % 3, i % 2, 0, 1'b0,
                   (i % 11) == 5, "R3");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule